// File: doc/BRIEF.md
# Serial Register-Access Slave for a Quad Digital Potentiometer

This block lets a host reach a small register map over a four-wire serial link of the SPI kind. The map holds four wiper registers, a non-volatile shadow copy of each, and one control register. The host lowers chip select and clocks in an instruction byte, most significant bit first. The top three bits of that byte are an opcode and the low five bits are a register address. One or more data bytes follow. The three serial inputs are synchronised into the system clock domain. Serial input is taken on each rising serial clock and serial output changes on each falling serial clock.

A write is held back until chip select is released, and only then committed. Bit 7 of the control register chooses the target of a wiper write. When it is clear, only the volatile wiper is written. When it is set, the non-volatile copy is written as well, and a busy timer starts. While that timer runs, the read-only busy flag in control register bit 0 is set, and every write except a control register write is refused. A read is a four-byte frame. During the third byte the slave returns the instruction it received, and during the fourth byte it returns the register contents. The four wiper values leave the block as a flat bus.

Top module: `dcp_spi_slave`

## Requirements
- R1: After reset every wiper and every non-volatile copy holds NV_RESET (8'h80), the control register reads 8'h00 and sdo is 0.
- R2: Bytes are shifted MSB first. An instruction byte has its opcode in bits 7:5 and its address in bits 4:0. Opcode 110 with address 00h..03h and control bit 7 clear writes only wiper[address], which appears on wiper_o bits [8*address +: 8].
- R3: During a frame wiper_o does not change. A write takes effect only after chip select rises.
- R4: A wiper write made while control bit 7 is 1 also writes the non-volatile copy. It sets control bit 0 for exactly BUSY_CYCLES system clocks, after which the bit clears.
- R5: A read frame is four bytes. Opcode 001 reads the control register and opcode 100 reads the register at the given address. During byte three sdo carries the received instruction and during byte four it carries the register value. A wiper address returns the volatile value when control bit 7 is 0 and the non-volatile value when it is 1.
- R6: Reading a non-volatile copy leaves the volatile wiper unchanged.
- R7: While control bit 0 is set, wiper writes are ignored, but control register writes (opcode 011, or opcode 110 at address 10h) and reads are still carried out.
- R8: Opcodes 010, 101 and 111 change nothing. Writes to addresses other than 00h..03h and 10h change nothing, and reads of those addresses return 8'h00.
- R9: A frame that ends before the instruction byte and one full data byte have been received changes nothing.
- R10: sdo is 0 while chip select is high and throughout write frames.
- R11: In a write with several data bytes, the last complete data byte is committed. For opcodes 001 and 011 the address bits are ignored. A control write stores data bits 7:1, and bit 0 always reads the busy flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| wiper_o | output | NW*DW | Volatile wiper values, wiper k in bits [DW*k +: DW] |

## Verification
Two functions can land in the same cycle. One is the commit made when chip select rises. The other is the busy timer, which counts down and blocks writes. The bench arranges this overlap by sending a wiper write and a control write immediately after a non-volatile write. It then checks that the wiper write was refused and that the control write was accepted with the flag still set. After the flag clears, the same wiper write is sent again and must now be accepted. This shows that the gate follows the timer and not the order in which the frames arrived.

// File: rtl/dcp_spi_pkg.sv
package dcp_spi_pkg;
    localparam int OP_W = 3;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 5'h10;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'b000,
        OP_CTL_RD = 3'b001,
        OP_CTL_WR = 3'b011,
        OP_REG_RD = 3'b100,
        OP_REG_WR = 3'b110
    } op_e;
endpackage

// File: rtl/dcp_spi_sync.sv
module dcp_spi_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcp_spi_shifter.sv
module dcp_spi_shifter
    import dcp_spi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_s,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_value,
    output logic          frame_end,
    output logic [DW-1:0] instr_o,
    output logic [DW-1:0] data_o,
    output logic          have_data_o,
    output logic          sdo_o
);
    localparam int BW = $clog2(DW);
    localparam int CW = 3;
    localparam logic [CW-1:0] CNT_MAX = 3'd4;

    typedef struct packed {
        logic          sck_prev;
        logic          cs_prev;
        logic [BW-1:0] bit_idx;
        logic [CW-1:0] byte_cnt;
        logic [DW-1:0] shreg;
        logic [DW-1:0] instr;
        logic [DW-1:0] data;
        logic [DW-1:0] rd;
        logic          have_instr;
        logic          have_data;
        logic          sdo;
    } sh_t;

    sh_t st_d, st_q;
    logic rise, fall, is_read;
    logic [DW-1:0] sh_next;
    logic [BW-1:0] out_idx;
    logic [OP_W-1:0] op;

    always_comb begin
        st_d = st_q;
        st_d.sck_prev = sck_s;
        st_d.cs_prev = cs_n_s;
        rise = !st_q.sck_prev && sck_s;
        fall = st_q.sck_prev && !sck_s;
        frame_end = !st_q.cs_prev && cs_n_s;
        op = st_q.instr[DW-1 -: OP_W];
        is_read = st_q.have_instr && (op == OP_CTL_RD || op == OP_REG_RD);
        sh_next = {st_q.shreg[DW-2:0], sdi_s};
        out_idx = BW'(DW - 1) - st_q.bit_idx;

        if (cs_n_s) begin
            st_d.bit_idx = '0;
            st_d.byte_cnt = '0;
            st_d.shreg = '0;
            st_d.sdo = 1'b0;
            st_d.have_instr = 1'b0;
            st_d.have_data = 1'b0;
        end else begin
            if (rise) begin
                st_d.shreg = sh_next;
                if (st_q.bit_idx == BW'(DW - 1)) begin
                    st_d.bit_idx = '0;
                    if (st_q.byte_cnt == '0) begin
                        st_d.instr = sh_next;
                        st_d.have_instr = 1'b1;
                    end else begin
                        st_d.data = sh_next;
                        st_d.have_data = 1'b1;
                    end
                    if (st_q.byte_cnt == CW'(1)) st_d.rd = rd_value;
                    if (st_q.byte_cnt != CNT_MAX) st_d.byte_cnt = st_q.byte_cnt + CW'(1);
                end else begin
                    st_d.bit_idx = st_q.bit_idx + BW'(1);
                end
            end
            if (fall) begin
                st_d.sdo = 1'b0;
                if (is_read && st_q.byte_cnt == CW'(2)) st_d.sdo = st_q.instr[out_idx];
                if (is_read && st_q.byte_cnt == CW'(3)) st_d.sdo = st_q.rd[out_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign instr_o = st_q.instr;
    assign data_o = st_q.data;
    assign have_data_o = st_q.have_data;
    assign sdo_o = st_q.sdo;
endmodule

// File: rtl/dcp_spi_regs.sv
module dcp_spi_regs
    import dcp_spi_pkg::*;
#(
    parameter int DW = 8,
    parameter int NW = 4,
    parameter int BUSY_CYCLES = 1000000,
    parameter logic [DW-1:0] NV_RESET = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic [DW-1:0]    instr,
    input  logic [DW-1:0]    data,
    input  logic             have_data,
    output logic [DW-1:0]    rd_value,
    output logic [NW*DW-1:0] wiper_o,
    output logic             wip_o,
    output logic [DW-1:0]    ctl_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam int IDXW = (NW > 1) ? $clog2(NW) : 1;

    typedef struct packed {
        logic [NW-1:0][DW-1:0] wr;
        logic [NW-1:0][DW-1:0] nv;
        logic [DW-2:0]         ctl_hi;
        logic [CW-1:0]         busy;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [OP_W-1:0] op;
    logic [ADDR_W-1:0] addr;
    logic [IDXW-1:0] widx;
    logic wip, wiper_hit, ctl_hit_wr, ctl_hit_rd, vol_both;
    logic [DW-1:0] ctl;

    always_comb begin
        rf_d = rf_q;
        op = instr[DW-1 -: OP_W];
        addr = instr[ADDR_W-1:0];
        widx = addr[IDXW-1:0];
        wip = (rf_q.busy != '0);
        ctl = {rf_q.ctl_hi, wip};
        vol_both = rf_q.ctl_hi[DW-2];
        wiper_hit = (32'(addr) < NW);
        ctl_hit_wr = (op == OP_CTL_WR) || (op == OP_REG_WR && addr == CTL_ADDR);
        ctl_hit_rd = (op == OP_CTL_RD) || (op == OP_REG_RD && addr == CTL_ADDR);

        if (wip) rf_d.busy = rf_q.busy - CW'(1);

        if (frame_end && have_data) begin
            if (ctl_hit_wr) begin
                rf_d.ctl_hi = data[DW-1:1];
            end else if (op == OP_REG_WR && wiper_hit && !wip) begin
                rf_d.wr[widx] = data;
                if (vol_both) begin
                    rf_d.nv[widx] = data;
                    rf_d.busy = CW'(BUSY_CYCLES);
                end
            end
        end

        rd_value = '0;
        if (ctl_hit_rd) rd_value = ctl;
        else if (op == OP_REG_RD && wiper_hit) rd_value = vol_both ? rf_q.nv[widx] : rf_q.wr[widx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.wr <= {NW{NV_RESET}};
            rf_q.nv <= {NW{NV_RESET}};
            rf_q.ctl_hi <= '0;
            rf_q.busy <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign wiper_o = rf_q.wr;
    assign wip_o = wip;
    assign ctl_o = ctl;
endmodule

// File: rtl/dcp_spi_slave.sv
module dcp_spi_slave #(
    parameter int DW = 8,
    parameter int NW = 4,
    parameter int BUSY_CYCLES = 1000000,
    parameter logic [DW-1:0] NV_RESET = 8'h80,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             sdi,
    output logic             sdo,
    output logic [NW*DW-1:0] wiper_o
);
    logic [2:0] sync_q;
    logic cs_n_s, sck_s, sdi_s;
    logic frame_end, have_data, wip;
    logic [DW-1:0] instr, data, rd_value, ctl;

    dcp_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({cs_n, sck, sdi}), .q_o(sync_q)
    );

    assign cs_n_s = sync_q[2];
    assign sck_s = sync_q[1];
    assign sdi_s = sync_q[0];

    dcp_spi_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s), .sdi_s(sdi_s),
        .rd_value(rd_value), .frame_end(frame_end), .instr_o(instr), .data_o(data),
        .have_data_o(have_data), .sdo_o(sdo)
    );

    dcp_spi_regs #(.DW(DW), .NW(NW), .BUSY_CYCLES(BUSY_CYCLES), .NV_RESET(NV_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .instr(instr), .data(data),
        .have_data(have_data), .rd_value(rd_value), .wiper_o(wiper_o), .wip_o(wip), .ctl_o(ctl)
    );
endmodule

// File: rtl/dcp_spi_checker.sv
module dcp_spi_checker #(
    parameter int DW = 8,
    parameter int NW = 4,
    parameter int BUSY_CYCLES = 1000000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n_s,
    input logic             frame_end,
    input logic             have_data,
    input logic [2:0]       op,
    input logic             wip,
    input logic [NW*DW-1:0] wiper,
    input logic [DW-2:0]    ctl_rw,
    input logic             sdo
);
    logic [31:0] wip_run;
    logic bad_op;

    assign bad_op = (op == 3'b010) || (op == 3'b101) || (op == 3'b111);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wip_run <= '0;
        else        wip_run <= wip ? wip_run + 32'd1 : 32'd0;
    end

    a_r3_commit_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper) |-> $past(frame_end));

    a_r10_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !sdo);

    a_r7_busy_blocks_wiper: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && wip) |=> $stable(wiper));

    a_r8_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && bad_op) |=> ($stable(wiper) && $stable(ctl_rw)));

    a_r9_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !have_data) |=> ($stable(wiper) && $stable(ctl_rw)));

    a_r4_wip_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(frame_end));

    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (wip_run == 32'(BUSY_CYCLES)));
endmodule

bind dcp_spi_slave dcp_spi_checker #(.DW(DW), .NW(NW), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .frame_end(frame_end),
    .have_data(have_data), .op(instr[DW-1:DW-3]), .wip(wip), .wiper(wiper_o),
    .ctl_rw(ctl[DW-1:1]), .sdo(sdo)
);

// File: tb/dcp_spi_slave_test.sv
module dcp_spi_slave_test;
    localparam int HALF = 6;
    localparam int BUSY = 1500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic [31:0] wiper_o;

    int vectors = 0;
    int errors = 0;
    logic [7:0] wm [4];
    logic [7:0] nvm [4];
    logic [6:0] ctlm;

    always #10 clk = ~clk;

    dcp_spi_slave #(.BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo), .wiper_o(wiper_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic end_frame();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic xfer(input int nbits, input logic [31:0] tx, input bit keep, output logic [31:0] rx);
        rx = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = tx[31-i];
            repeat (HALF) @(negedge clk);
            rx[31-i] = sdo;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        if (!keep) end_frame();
    endtask

    function automatic logic [31:0] wipers_m();
        return {wm[3], wm[2], wm[1], wm[0]};
    endfunction

    task automatic wr_frame(input logic [7:0] ins, input logic [7:0] dat);
        logic [31:0] rx;
        xfer(16, {ins, dat, 16'h0}, 1'b0, rx);
        check("R10 sdo in write frame", rx, 32'h0);
    endtask

    task automatic rd_frame(input string tag, input logic [7:0] ins, input logic [7:0] exp);
        logic [31:0] rx;
        xfer(32, {ins, 8'h00, 8'h00, 8'h00}, 1'b0, rx);
        check("R5 echo of instruction", {24'h0, rx[15:8]}, {24'h0, ins});
        check(tag, {24'h0, rx[7:0]}, {24'h0, exp});
    endtask

    task automatic rd_ctl(output logic [7:0] v);
        logic [31:0] rx;
        xfer(32, {8'h20, 24'h0}, 1'b0, rx);
        v = rx[7:0];
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        v = 8'h01;
        for (int n = 0; n < 10 && v[0]; n++) rd_ctl(v);
        check(tag, {24'h0, v}, {24'h0, ctlm, 1'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] rx;
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin wm[i] = 8'h80; nvm[i] = 8'h80; end
        ctlm = '0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 wipers after reset", wiper_o, 32'h80808080);
        check("R1 sdo after reset", {31'h0, sdo}, 32'h0);
        rd_frame("R1 control reads zero", 8'h20, 8'h00);
        for (int a = 0; a < 4; a++) rd_frame("R1 wiper read", 8'h80 | 8'(a), 8'h80);

        // R2/R3 sweep of volatile-only writes
        for (int a = 0; a < 4; a++) begin
            for (int k = 0; k < 8; k++) begin
                v = 8'((k * 37 + a * 91 + 5) & 255);
                xfer(16, {8'hC0 | 8'(a), v, 16'h0}, 1'b1, rx);
                check("R3 wiper held during frame", wiper_o, wipers_m());
                end_frame();
                wm[a] = v;
                check("R2 wiper after write", wiper_o, wipers_m());
                rd_frame("R5 wiper read volatile", 8'h80 | 8'(a), v);
            end
        end
        check("R10 sdo idle after frames", {31'h0, sdo}, 32'h0);

        // R11 multi-byte write, address bits ignored on control opcodes
        xfer(24, {8'hC1, 8'h12, 8'h34, 8'h00}, 1'b0, rx);
        wm[1] = 8'h34;
        check("R11 last data byte committed", wiper_o, wipers_m());
        wr_frame(8'h7F, 8'h4B);
        ctlm = 7'h25;
        rd_frame("R11 control write keeps bits 7:1", 8'h3F, 8'h4A);
        wr_frame(8'hD0, 8'h00);
        ctlm = '0;
        rd_frame("R11 control via address 10h", 8'h90, 8'h00);

        // R6 non-volatile read leaves wiper intact
        wr_frame(8'hC0, 8'h11);
        wm[0] = 8'h11;
        wr_frame(8'h60, 8'h80);
        ctlm = 7'h40;
        rd_frame("R6 reads non-volatile copy", 8'h80, nvm[0]);
        check("R6 wiper unchanged by read", wiper_o, wipers_m());

        // R4/R7 non-volatile write and busy window
        wr_frame(8'hC2, 8'h3C);
        wm[2] = 8'h3C; nvm[2] = 8'h3C;
        check("R4 wiper written with copy", wiper_o, wipers_m());
        wr_frame(8'hC1, 8'h55);
        check("R7 wiper write refused while busy", wiper_o, wipers_m());
        wr_frame(8'h60, 8'hC0);
        ctlm = 7'h60;
        rd_frame("R7 control write accepted, R4 busy set", 8'h20, 8'hC1);
        rd_frame("R5 non-volatile read", 8'h82, 8'h3C);
        wait_idle("R4 busy flag clears");
        wr_frame(8'hC1, 8'h55);
        wm[1] = 8'h55; nvm[1] = 8'h55;
        check("R7 wiper write after busy", wiper_o, wipers_m());
        wr_frame(8'h60, 8'h00);
        ctlm = '0;
        wait_idle("R4 busy clears again");
        rd_frame("R5 volatile read after clear", 8'h81, 8'h55);

        // R8 unused opcodes and unmapped addresses
        for (int o = 0; o < 3; o++) begin
            v = (o == 0) ? 8'h40 : (o == 1) ? 8'hA0 : 8'hE0;
            wr_frame(v, 8'hAA);
            check("R8 unused opcode wipers", wiper_o, wipers_m());
            rd_frame("R8 unused opcode control", 8'h20, 8'h00);
        end
        for (int u = 0; u < 4; u++) begin
            v = (u == 0) ? 8'h05 : (u == 1) ? 8'h0F : (u == 2) ? 8'h11 : 8'h1F;
            wr_frame(8'hC0 | v, 8'hAA);
            check("R8 unmapped write wipers", wiper_o, wipers_m());
            rd_frame("R8 unmapped read zero", 8'h80 | v, 8'h00);
        end
        rd_frame("R8 control after unmapped", 8'h20, 8'h00);

        // R9 short frames
        xfer(8, {8'hC3, 24'h0}, 1'b0, rx);
        check("R9 instruction only", wiper_o, wipers_m());
        xfer(13, {8'hC3, 8'hFF, 16'h0}, 1'b0, rx);
        check("R9 partial data byte", wiper_o, wipers_m());
        xfer(12, {8'h60, 8'hFE, 16'h0}, 1'b0, rx);
        rd_frame("R9 partial control write", 8'h20, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule